// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Core

This block models the front end of a synchronous SRAM with one shared data bus, double-data-rate transfers and a fixed burst of two. Each external command cycle is split into two halves of an internal fast clock. The block tracks which half is current with its own `phase` output: 0 for the first half, 1 for the second. Commands (a load strobe, a read/write select and an address) are accepted only in first halves.

A write brings two data beats, one per half of the following command cycle. Each beat has its own per-lane enables, and each lane is 9 bits wide. The beats are gathered into one double-width word and written to the array in a single access. Lanes whose enable is low keep their stored value.

A read fetches one double-width word and returns it on the output bus as two beats. The first beat appears five half-cycles after the command half, and a valid flag marks each beat. A read that follows a write to the same address returns the new data, even when the write's beats reach the block after the read command.

The data bus is modelled as a split input and output pair. `q_valid` doubles as the output-enable of the shared bus.

Top module: `ddr_b2_sram`

## Requirements
- R1: `phase` alternates every fast clock cycle, with 0 marking the first half of a command cycle. A load strobe presented while `phase` is 1 is ignored: it starts no read and changes no memory contents.
- R2: For a write command in half-cycle t (`cmd_ld`=1, `cmd_rd`=0, `phase`=0), `dq_in`/`lane_we` in half-cycle t+2 form the low beat and those in t+3 form the high beat of the stored word.
- R3: For a read command in half-cycle t (`cmd_ld`=1, `cmd_rd`=1, `phase`=0), `q_valid` is 1 in half-cycles t+5 and t+6. `dq_out` carries the low beat in t+5 and the high beat in t+6. Addresses 0 and the highest address work alike.
- R4: Outside read beats, `q_valid` is 0 and `dq_out` is all zero (bus released).
- R5: `lane_we` bit k of a beat gates `dq_in` bits 9k+8:9k of that beat. A lane with its bit at 0 keeps its previous contents, and a write with all bits 0 changes nothing.
- R6: A read issued after a write to the same address returns the written lanes, even when issued in the very next command cycle.
- R7: A read issued before a write to the same address returns the data stored before that write.
- R8: `cmd_ld`=0 is no operation: no read beats follow and bus data in later cycles is not stored.
- R9: Reads on consecutive command cycles produce an unbroken stream of valid beats in command order.
- R10: While `rst` is 1, `q_valid` is 0, `dq_out` is zero and `phase` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two cycles per command cycle |
| rst | input | 1 | Synchronous active-high reset |
| cmd_ld | input | 1 | Load strobe; 1 starts an operation in a first half |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 6 | Double-word address |
| dq_in | input | 36 | Write data beat |
| lane_we | input | 4 | Per-lane write enable for the current beat |
| phase | output | 1 | 0 = first half, 1 = second half of the command cycle |
| q_valid | output | 1 | Read beat present; also the bus output enable |
| dq_out | output | 36 | Read data beat |

## Verification
A read can arrive while an older write to the same address is still waiting for its beats. Its array fetch and that write's commit then land in the same window, and the commit must be folded into the read in flight. The bench provokes this by issuing a read one command cycle after a write to that address, with full and with partial lane enables, and compares both returned beats against a model that applies operations in issue order. The opposite order, a read immediately followed by a write, is judged the same way and must return the old word.

// File: rtl/ddr_b2_pkg.sv
package ddr_b2_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DQ_W        = 36;
    localparam int LANE_W      = 9;
    localparam int ADDR_W      = 6;
    localparam int LANES       = DQ_W / LANE_W;
    localparam int WORD_W      = 2 * DQ_W;
    localparam int WLANES      = 2 * LANES;
    localparam int DEPTH       = 1 << ADDR_W;
    localparam int RD_LAT_HALF = 5;
    localparam int RD_STG      = RD_LAT_HALF - 1;

    typedef logic [DQ_W-1:0]   beat_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LANES-1:0]  lmask_t;
    typedef logic [WLANES-1:0] wmask_t;

    typedef struct packed {
        logic  v;
        addr_t addr;
        word_t word;
    } rd_stage_t;

    typedef struct packed {
        logic   we;
        addr_t  addr;
        word_t  data;
        wmask_t mask;
    } commit_t;

    function automatic word_t merge_lanes(word_t base, word_t upd, wmask_t m);
        word_t r = base;
        for (int i = 0; i < WLANES; i++) begin
            if (m[i]) r[i*LANE_W +: LANE_W] = upd[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction
endpackage

// File: rtl/ddr_b2_array.sv
module ddr_b2_array
    import ddr_b2_pkg::*;
(
    input  logic    clk,
    input  addr_t   rd_addr,
    output word_t   rd_data,
    input  commit_t cm
);
    timeunit 1ns;
    timeprecision 100ps;

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (cm.we) mem[cm.addr] <= merge_lanes(mem[cm.addr], cm.data, cm.mask);
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/ddr_b2_wgather.sv
module ddr_b2_wgather
    import ddr_b2_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    phase,
    input  logic    ld,
    input  logic    rd,
    input  addr_t   addr,
    input  beat_t   dq_in,
    input  lmask_t  lane_we,
    output commit_t cm
);
    timeunit 1ns;
    timeprecision 100ps;

    logic   wq_v, g_v;
    addr_t  wq_addr, g_addr;
    beat_t  g_lo;
    lmask_t g_m0;

    always_ff @(posedge clk) begin
        if (rst) begin
            wq_v    <= 1'b0;
            wq_addr <= '0;
            g_v     <= 1'b0;
            g_addr  <= '0;
            g_lo    <= '0;
            g_m0    <= '0;
        end else if (!phase) begin
            g_v <= wq_v;
            if (wq_v) begin
                g_addr <= wq_addr;
                g_lo   <= dq_in;
                g_m0   <= lane_we;
            end
            wq_v <= ld & ~rd;
            if (ld & ~rd) wq_addr <= addr;
        end else begin
            g_v <= 1'b0;
        end
    end

    always_comb begin
        cm.we   = g_v & phase;
        cm.addr = g_addr;
        cm.data = {dq_in, g_lo};
        cm.mask = {lane_we, g_m0};
    end
endmodule

// File: rtl/ddr_b2_rpipe.sv
module ddr_b2_rpipe
    import ddr_b2_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    phase,
    input  logic    ld,
    input  logic    rd,
    input  addr_t   addr,
    input  word_t   arr_data,
    input  commit_t cm,
    output logic    q_valid,
    output beat_t   dq_out
);
    timeunit 1ns;
    timeprecision 100ps;

    rd_stage_t stg [RD_STG];
    logic      out_v, out_b;
    word_t     out_w;

    function automatic rd_stage_t fold(rd_stage_t s, commit_t c);
        rd_stage_t r = s;
        if (c.we && s.v && s.addr == c.addr) r.word = merge_lanes(s.word, c.data, c.mask);
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RD_STG; i++) stg[i] <= '0;
        end else begin
            stg[0].v    <= ld & rd & ~phase;
            stg[0].addr <= addr;
            stg[0].word <= arr_data;
            for (int i = 1; i < RD_STG; i++) stg[i] <= fold(stg[i-1], cm);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_v <= 1'b0;
            out_b <= 1'b0;
            out_w <= '0;
        end else if (stg[RD_STG-1].v) begin
            out_v <= 1'b1;
            out_b <= 1'b0;
            out_w <= fold(stg[RD_STG-1], cm).word;
        end else if (out_v && !out_b) begin
            out_b <= 1'b1;
        end else begin
            out_v <= 1'b0;
            out_b <= 1'b0;
        end
    end

    assign q_valid = out_v;
    assign dq_out  = !out_v ? '0 : (out_b ? out_w[WORD_W-1:DQ_W] : out_w[DQ_W-1:0]);
endmodule

// File: rtl/ddr_b2_sram.sv
module ddr_b2_sram
    import ddr_b2_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_ld,
    input  logic                  cmd_rd,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic [DQ_W-1:0]       dq_in,
    input  logic [LANES-1:0]      lane_we,
    output logic                  phase,
    output logic                  q_valid,
    output logic [DQ_W-1:0]       dq_out
);
    timeunit 1ns;
    timeprecision 100ps;

    logic    ph;
    commit_t cm;
    word_t   arr_q;

    always_ff @(posedge clk) begin
        if (rst) ph <= 1'b0;
        else     ph <= ~ph;
    end
    assign phase = ph;

    ddr_b2_wgather u_wg (
        .clk(clk), .rst(rst), .phase(ph), .ld(cmd_ld), .rd(cmd_rd),
        .addr(cmd_addr), .dq_in(dq_in), .lane_we(lane_we), .cm(cm)
    );

    ddr_b2_array u_arr (
        .clk(clk), .rd_addr(cmd_addr), .rd_data(arr_q), .cm(cm)
    );

    ddr_b2_rpipe u_rp (
        .clk(clk), .rst(rst), .phase(ph), .ld(cmd_ld), .rd(cmd_rd),
        .addr(cmd_addr), .arr_data(arr_q), .cm(cm),
        .q_valid(q_valid), .dq_out(dq_out)
    );
endmodule

// File: rtl/ddr_b2_sram_chk.sv
module ddr_b2_sram_chk
    import ddr_b2_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            cmd_ld,
    input logic            cmd_rd,
    input logic            phase,
    input logic            q_valid,
    input logic [DQ_W-1:0] dq_out
);
    timeunit 1ns;
    timeprecision 100ps;

    a_r4_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !q_valid |-> dq_out == '0);

    a_r1_phase_alt: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> phase != $past(phase));

    a_r3_lead_beat_second_half: assert property (@(posedge clk) disable iff (rst)
        $rose(q_valid) |-> phase);

    a_r3_two_beats: assert property (@(posedge clk) disable iff (rst)
        $rose(q_valid) |=> q_valid);

    a_r8_beats_need_read: assert property (@(posedge clk) disable iff (rst)
        $rose(q_valid) |-> $past(cmd_ld && cmd_rd && !phase, 5));

    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> (!q_valid && !phase));
endmodule

bind ddr_b2_sram ddr_b2_sram_chk u_chk (
    .clk(clk), .rst(rst), .cmd_ld(cmd_ld), .cmd_rd(cmd_rd),
    .phase(phase), .q_valid(q_valid), .dq_out(dq_out)
);

// File: tb/ddr_b2_sram_tb.sv
module ddr_b2_sram_tb;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 0;
    logic        rst = 1;
    logic        cmd_ld = 0, cmd_rd = 0;
    logic [5:0]  cmd_addr = 0;
    logic [35:0] dq_in = 0;
    logic [3:0]  lane_we = 0;
    logic        phase, q_valid;
    logic [35:0] dq_out;

    int checks = 0, bad = 0, t = 0;
    logic [71:0] mdl [64];
    logic        ev [16];
    logic [35:0] ed [16];
    string       et [16];
    logic [35:0] sd [16];
    logic [3:0]  sm [16];

    ddr_b2_sram u_dut (
        .clk(clk), .rst(rst), .cmd_ld(cmd_ld), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
        .dq_in(dq_in), .lane_we(lane_we), .phase(phase), .q_valid(q_valid), .dq_out(dq_out)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at half-cycle %0d: got %h expected %h", req, t, act, exp);
        end
    endtask

    function automatic logic [71:0] upd(logic [71:0] o, logic [35:0] d0, logic [35:0] d1,
                                        logic [3:0] m0, logic [3:0] m1);
        logic [71:0] r = o;
        logic [71:0] n = {d1, d0};
        logic [7:0]  m = {m1, m0};
        for (int k = 0; k < 8; k++) if (m[k]) r[9*k +: 9] = n[9*k +: 9];
        return r;
    endfunction

    task automatic tick(input logic ld, input logic rd, input logic [5:0] a);
        int s;
        @(negedge clk);
        t++;
        s = t % 16;
        chk(phase == t[0], "R1", {35'b0, phase}, {35'b0, t[0]});
        if (ev[s]) chk(q_valid && dq_out == ed[s], et[s], dq_out, ed[s]);
        else       chk(!q_valid && dq_out == '0, "R4", dq_out, 36'h0);
        ev[s] = 0;
        cmd_ld = ld; cmd_rd = rd; cmd_addr = a;
        dq_in = sd[s]; lane_we = sm[s];
        sd[s] = 0; sm[s] = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0);
    endtask

    task automatic align();
        if ((t + 1) % 2 != 0) tick(0, 0, 0);
    endtask

    task automatic put_beats(input int tn, input logic [35:0] d0, input logic [35:0] d1,
                             input logic [3:0] m0, input logic [3:0] m1);
        sd[(tn+2)%16] = d0; sm[(tn+2)%16] = m0;
        sd[(tn+3)%16] = d1; sm[(tn+3)%16] = m1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [35:0] d0, input logic [35:0] d1,
                      input logic [3:0] m0, input logic [3:0] m1);
        align();
        put_beats(t + 1, d0, d1, m0, m1);
        mdl[a] = upd(mdl[a], d0, d1, m0, m1);
        tick(1, 0, a);
    endtask

    task automatic rdq(input logic [5:0] a, input string tag);
        int tn;
        align();
        tn = t + 1;
        ev[(tn+5)%16] = 1; ed[(tn+5)%16] = mdl[a][35:0];  et[(tn+5)%16] = tag;
        ev[(tn+6)%16] = 1; ed[(tn+6)%16] = mdl[a][71:36]; et[(tn+6)%16] = tag;
        tick(1, 1, a);
    endtask

    task automatic test_reset();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!q_valid && dq_out == '0 && !phase, "R10", {34'b0, phase, q_valid}, 36'h0);
        end
        rst = 0;
        t = 0;
    endtask

    task automatic test_basic();
        wr(5, 36'h123456789, 36'hABCDEF012, 4'hF, 4'hF);
        wr(0, 36'h000000001, 36'h800000000, 4'hF, 4'hF);
        wr(63, 36'hFEDCBA987, 36'h135792468, 4'hF, 4'hF);
        idle(4);
        rdq(5, "R2");
        idle(8);
        rdq(0, "R3");
        idle(8);
        rdq(63, "R3");
        idle(8);
    endtask

    task automatic test_lanes();
        wr(9, 36'hFFFFFFFFF, 36'hFFFFFFFFF, 4'hF, 4'hF);
        wr(9, 36'h000000000, 36'h000000000, 4'b0101, 4'b1010);
        idle(4);
        rdq(9, "R5");
        idle(8);
        wr(9, 36'h555555555, 36'h555555555, 4'b0000, 4'b0000);
        idle(4);
        rdq(9, "R5");
        idle(8);
    endtask

    task automatic test_coherent();
        wr(12, 36'h0A0A0A0A0, 36'h0B0B0B0B0, 4'hF, 4'hF);
        rdq(12, "R6");
        idle(8);
        wr(12, 36'h111111111, 36'h222222222, 4'b0011, 4'b1100);
        rdq(12, "R6");
        idle(8);
    endtask

    task automatic test_order();
        wr(13, 36'h0C0C0C0C0, 36'h0D0D0D0D0, 4'hF, 4'hF);
        idle(4);
        rdq(13, "R7");
        wr(13, 36'h333333333, 36'h444444444, 4'hF, 4'hF);
        rdq(13, "R6");
        idle(8);
    endtask

    task automatic test_nop();
        align();
        put_beats(t + 1, 36'hDEADBEEF0, 36'hDEADBEEF1, 4'hF, 4'hF);
        tick(0, 0, 5);
        idle(6);
        rdq(5, "R8");
        idle(8);
        align();
        tick(0, 0, 0);
        put_beats(t + 1, 36'hBADBADBAD, 36'hBADBADBAD, 4'hF, 4'hF);
        tick(1, 0, 5);
        tick(0, 0, 0);
        tick(1, 1, 5);
        idle(8);
        rdq(5, "R1");
        idle(8);
    endtask

    task automatic test_stream();
        for (int i = 0; i < 4; i++)
            wr(6'(20 + i), 36'(64'h100000000 * i + 64'h11), 36'(64'h22 + i), 4'hF, 4'hF);
        idle(4);
        for (int i = 0; i < 4; i++) rdq(6'(20 + i), "R9");
        idle(10);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            ev[i] = 0; ed[i] = 0; et[i] = ""; sd[i] = 0; sm[i] = 0;
        end
        for (int i = 0; i < 64; i++) mdl[i] = 0;
        test_reset();
        test_basic();
        test_lanes();
        test_coherent();
        test_order();
        test_nop();
        test_stream();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(1000000);
        checks++;
        bad++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule